// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns already-digitized supply comparator flags and a push-button manual reset into a clean system reset for the rest of the chip. One flag per monitored rail reports that the rail is above its threshold. The main rail and the manual reset both hold the system in reset. Once both have cleared, the reset is released only after a programmable number of millisecond ticks, chosen by a 2-bit select. The same release delay applies from power-up.

The block also passes undelayed early-warning outputs straight through to the board. These are a main-rail low flag and one fail flag for each of the two auxiliary rails. A volatile fault-cause register records why the system went down. Software arms it by writing ones. Each cause then pulls its own bit to zero and leaves it there until software writes the register again.

The comparator flags, the watchdog pulse and the tick are taken as synchronous to `clk`. The manual reset pin is asynchronous, so it is synchronized and debounced inside the block.

Top module: `supv_reset_gen`

## Requirements
- R1: The release delay in `ms_tick_i` pulses follows `dly_sel_i`: 2'b00 gives 50, 2'b01 gives 200, 2'b10 gives 400 and 2'b11 gives 800.
- R2: When `main_ok_i` is low, `sys_rst_o` is high in that same cycle and stays high.
- R3: After `rst` is released, `sys_rst_o` stays high until the selected number of ticks has passed.
- R4: Reset releases only after `main_ok_i` has stayed high for the full selected delay. If the main rail drops during the countdown, the count restarts from zero once the rail is back.
- R5: While the debounced manual reset is low, reset is held. Reset releases one full selected delay after the debounced pin returns high.
- R6: A level change on `mr_n_i` is accepted only after it has stayed stable for `DEB_CYCLES` clocks, following a 2-flop synchronizer. A shorter low pulse neither asserts reset nor touches the fault register.
- R7: `early_low_n_o`, `rail2_fail_n_o` and `rail3_fail_n_o` follow `main_ok_i`, `rail2_ok_i` and `rail3_ok_i` in the same cycle. Each output is active low and has no delay.
- R8: `sys_rst_n_o` is always the complement of `sys_rst_o`.
- R9: Fault register layout: bit 7 main rail, bit 6 second rail, bit 5 third rail, bit 4 watchdog, bit 3 manual reset. Bits 2:0 always read 0. The register is 8'h00 after `rst`.
- R10: A write with `fr_we_i` loads `fr_wdata_i`, with bits 2:0 forced to 0, and needs no enable sequence. A fault bit is 0 in the cycle after its source is active and stays 0 until the next write. A source that is active in the same cycle as a write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| main_ok_i | input | 1 | Main rail above threshold |
| rail2_ok_i | input | 1 | Second rail above threshold |
| rail3_ok_i | input | 1 | Third rail above threshold |
| mr_n_i | input | 1 | Manual reset pin, active low, asynchronous |
| wdog_exp_i | input | 1 | Watchdog expiry pulse |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| dly_sel_i | input | 2 | Release delay select |
| fr_we_i | input | 1 | Fault register write strobe |
| fr_wdata_i | input | 8 | Fault register write data |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| early_low_n_o | output | 1 | Undelayed main-rail low warning, active low |
| rail2_fail_n_o | output | 1 | Second rail fail, active low |
| rail3_fail_n_o | output | 1 | Third rail fail, active low |
| fault_reg_o | output | 8 | Fault-cause register |

## Verification
Most internal faults in this block show up first on the reset pins.

- A release counter that does not clear, or that clears at the wrong time, shows up as a reset that lets go too early. This appears within one delay window after the main rail recovers, or after a brown-out in the middle of a countdown.
- A wrong delay decode shifts the release edge by whole ticks, so the bench brackets each release between one tick before and two ticks after the expected point.
- A stuck debouncer either ignores a held button or passes a short glitch. Either fault is visible on the reset output and on fault bit 3 within one debounce window.
- A wrong fault-bit priority shows up in the cycle after a source and a write coincide.

// File: rtl/supv_pkg.sv
package supv_pkg;

    localparam int FR_W        = 8;
    localparam int FR_MAIN_BIT = 7;
    localparam int FR_R2_BIT   = 6;
    localparam int FR_R3_BIT   = 5;
    localparam int FR_WD_BIT   = 4;
    localparam int FR_MR_BIT   = 3;
    localparam logic [FR_W-1:0] FR_MASK = 8'hF8;

    typedef struct packed {
        logic main_low;
        logic r2_low;
        logic r3_low;
        logic wd_exp;
        logic mr_act;
    } fault_src_t;

    function automatic int unsigned dly_pick(
        input logic [1:0]  sel,
        input int unsigned d0,
        input int unsigned d1,
        input int unsigned d2,
        input int unsigned d3
    );
        case (sel)
            2'b00:   return d0;
            2'b01:   return d1;
            2'b10:   return d2;
            default: return d3;
        endcase
    endfunction

    function automatic int unsigned max4(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c,
        input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/supv_mr_debounce.sv
module supv_mr_debounce #(
    parameter int DEB_CYCLES = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic active_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            level_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_n_i};
            if (sync_q[1] != level_q) begin
                if (cnt_q == CW'(DEB_CYCLES - 1)) begin
                    level_q <= sync_q[1];
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign active_o = ~level_q;
endmodule

// File: rtl/supv_release_timer.sv
module supv_release_timer
    import supv_pkg::*;
#(
    parameter int unsigned DLY0 = 50,
    parameter int unsigned DLY1 = 200,
    parameter int unsigned DLY2 = 400,
    parameter int unsigned DLY3 = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       rst_o
);
    localparam int unsigned DMAX = max4(DLY0, DLY1, DLY2, DLY3);
    localparam int CW = $clog2(DMAX + 1);

    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic [CW-1:0] last;

    assign last = CW'(dly_pick(sel_i, DLY0, DLY1, DLY2, DLY3) - 1);

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt_q <= '0;
            act_q <= 1'b1;
        end else if (act_q && tick_i) begin
            if (cnt_q >= last) begin
                cnt_q <= '0;
                act_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rst_o = act_q | hold_i;
endmodule

// File: rtl/supv_fault_reg.sv
module supv_fault_reg
    import supv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  fault_src_t      src_i,
    input  logic            we_i,
    input  logic [FR_W-1:0] wdata_i,
    output logic [FR_W-1:0] q_o
);
    logic [FR_W-1:0] q_r;
    logic [FR_W-1:0] nxt;
    logic [FR_W-1:0] clr;

    always_comb begin
        clr = '0;
        clr[FR_MAIN_BIT] = src_i.main_low;
        clr[FR_R2_BIT]   = src_i.r2_low;
        clr[FR_R3_BIT]   = src_i.r3_low;
        clr[FR_WD_BIT]   = src_i.wd_exp;
        clr[FR_MR_BIT]   = src_i.mr_act;
        nxt = we_i ? (wdata_i & FR_MASK) : q_r;
        nxt = nxt & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= nxt;
    end

    assign q_o = q_r;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int unsigned DLY0       = 50,
    parameter int unsigned DLY1       = 200,
    parameter int unsigned DLY2       = 400,
    parameter int unsigned DLY3       = 800,
    parameter int          DEB_CYCLES = 625
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       main_ok_i,
    input  logic       rail2_ok_i,
    input  logic       rail3_ok_i,
    input  logic       mr_n_i,
    input  logic       wdog_exp_i,
    input  logic       ms_tick_i,
    input  logic [1:0] dly_sel_i,
    input  logic       fr_we_i,
    input  logic [7:0] fr_wdata_i,
    output logic       sys_rst_o,
    output logic       sys_rst_n_o,
    output logic       early_low_n_o,
    output logic       rail2_fail_n_o,
    output logic       rail3_fail_n_o,
    output logic [7:0] fault_reg_o
);
    logic       mr_act;
    logic       hold;
    logic       rst_int;
    fault_src_t src;

    supv_mr_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk      (clk),
        .rst      (rst),
        .pin_n_i  (mr_n_i),
        .active_o (mr_act)
    );

    assign hold = ~main_ok_i | mr_act;

    supv_release_timer #(
        .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .hold_i (hold),
        .tick_i (ms_tick_i),
        .sel_i  (dly_sel_i),
        .rst_o  (rst_int)
    );

    always_comb begin
        src.main_low = ~main_ok_i;
        src.r2_low   = ~rail2_ok_i;
        src.r3_low   = ~rail3_ok_i;
        src.wd_exp   = wdog_exp_i;
        src.mr_act   = mr_act;
    end

    supv_fault_reg u_fr (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src),
        .we_i    (fr_we_i),
        .wdata_i (fr_wdata_i),
        .q_o     (fault_reg_o)
    );

    assign sys_rst_o      = rst_int;
    assign sys_rst_n_o    = ~rst_int;
    assign early_low_n_o  = main_ok_i;
    assign rail2_fail_n_o = rail2_ok_i;
    assign rail3_fail_n_o = rail3_ok_i;
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       main_ok_i,
    input logic       rail2_ok_i,
    input logic       ms_tick_i,
    input logic       fr_we_i,
    input logic       sys_rst_o,
    input logic [7:0] fault_reg_o
);
    // R2: a low main rail leaves reset asserted on the next edge
    a_r2_main_low_holds: assert property (@(posedge clk) disable iff (rst)
        !main_ok_i |=> sys_rst_o);

    // R4: reset can only let go on a tick
    a_r4_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> $past(ms_tick_i));

    // R9: unused bits stay zero
    a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        fault_reg_o[2:0] == 3'b000);

    // R10: an active source clears its bit
    a_r10_src_clears: assert property (@(posedge clk) disable iff (rst)
        !rail2_ok_i |=> !fault_reg_o[6]);

    // R10: a cleared bit stays cleared without a write
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (!fault_reg_o[7] && !fr_we_i) |=> !fault_reg_o[7]);
endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .main_ok_i   (main_ok_i),
    .rail2_ok_i  (rail2_ok_i),
    .ms_tick_i   (ms_tick_i),
    .fr_we_i     (fr_we_i),
    .sys_rst_o   (sys_rst_o),
    .fault_reg_o (fault_reg_o)
);

// File: tb/supv_reset_gen_bench.sv
`timescale 1ns/1ps
module supv_reset_gen_bench;
    localparam int TP  = 8;
    localparam int DEB = 625;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       main_ok_i = 1'b1, rail2_ok_i = 1'b1, rail3_ok_i = 1'b1;
    logic       mr_n_i = 1'b1, wdog_exp_i = 1'b0, ms_tick_i = 1'b0;
    logic [1:0] dly_sel_i = 2'b00;
    logic       fr_we_i = 1'b0;
    logic [7:0] fr_wdata_i = 8'h00;
    logic       sys_rst_o, sys_rst_n_o, early_low_n_o;
    logic       rail2_fail_n_o, rail3_fail_n_o;
    logic [7:0] fault_reg_o;

    int checks = 0, errors = 0, cyc = 0, tick_ph = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supv_reset_gen u_supv_reset_gen (.*);

    always @(posedge clk) begin
        tick_ph   <= (tick_ph == TP - 1) ? 0 : tick_ph + 1;
        ms_tick_i <= (tick_ph == TP - 1);
        cyc       <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_fr(input logic [7:0] d);
        @(negedge clk);
        fr_we_i = 1'b1; fr_wdata_i = d;
        @(negedge clk);
        fr_we_i = 1'b0;
        #1;
    endtask

    // {select, ticks}
    localparam logic [11:0] VEC [4] = '{
        {2'b00, 10'd50}, {2'b01, 10'd200}, {2'b10, 10'd400}, {2'b11, 10'd800}
    };

    initial begin
        cyc_n(3);
        // R9: register cleared at power-up
        chk("R9 power-up value", fault_reg_o, 8'h00);
        chk("R3 reset held during rst", sys_rst_o, 1'b1);
        @(negedge clk); rst = 1'b0;
        // R3: power-up delay with select 00 (50 ticks)
        cyc_n(49 * TP);
        chk("R3 still in reset before delay", sys_rst_o, 1'b1);
        chk("R8 complement", sys_rst_n_o, 1'b0);
        cyc_n(3 * TP);
        chk("R3 released after delay", sys_rst_o, 1'b0);
        chk("R8 complement released", sys_rst_n_o, 1'b1);

        // R1 / R4 table walk over every select value
        for (int i = 0; i < 4; i++) begin
            dly_sel_i = VEC[i][11:10];
            wr_fr(8'hFF);
            chk("R10 write arms register", fault_reg_o, 8'hF8);
            @(negedge clk); main_ok_i = 1'b0; #1;
            chk("R2 immediate reset", sys_rst_o, 1'b1);
            chk("R7 early low follows", early_low_n_o, 1'b0);
            cyc_n(5);
            chk("R10 main fault bit7 cleared", fault_reg_o, 8'h78);
            @(negedge clk); main_ok_i = 1'b1;
            cyc_n((int'(VEC[i][9:0]) - 1) * TP);
            chk("R1 held before selected delay", sys_rst_o, 1'b1);
            cyc_n(3 * TP);
            chk("R1 released after selected delay", sys_rst_o, 1'b0);
            chk("R10 bit7 stays cleared", fault_reg_o, 8'h78);
        end

        // R4: brown-out during the countdown restarts it (select 01, 200 ticks)
        dly_sel_i = 2'b01;
        @(negedge clk); main_ok_i = 1'b0;
        cyc_n(3); main_ok_i = 1'b1;
        cyc_n(100 * TP);
        main_ok_i = 1'b0;
        cyc_n(3); main_ok_i = 1'b1;
        cyc_n(150 * TP);
        chk("R4 countdown restarted", sys_rst_o, 1'b1);
        cyc_n(60 * TP);
        chk("R4 released after full delay", sys_rst_o, 1'b0);

        // R6: short glitch on the manual reset is ignored
        dly_sel_i = 2'b00;
        wr_fr(8'hFF);
        @(negedge clk); mr_n_i = 1'b0;
        cyc_n(100); mr_n_i = 1'b1;
        cyc_n(DEB + 20);
        chk("R6 glitch no reset", sys_rst_o, 1'b0);
        chk("R6 glitch no fault", fault_reg_o, 8'hF8);

        // R5: held manual reset, release one delay after the pin goes high
        @(negedge clk); mr_n_i = 1'b0;
        cyc_n(DEB + 20);
        chk("R5 manual reset asserts", sys_rst_o, 1'b1);
        chk("R10 manual fault bit3 cleared", fault_reg_o, 8'hF0);
        cyc_n(2000);
        chk("R5 held while pin low", sys_rst_o, 1'b1);
        mr_n_i = 1'b1;
        cyc_n(DEB + 15);
        cyc_n(47 * TP);
        chk("R5 held through delay", sys_rst_o, 1'b1);
        cyc_n(5 * TP);
        chk("R5 released after delay", sys_rst_o, 1'b0);

        // R7 / R10: auxiliary rails
        wr_fr(8'hFF);
        @(negedge clk); rail2_ok_i = 1'b0; #1;
        chk("R7 rail2 fail follows", rail2_fail_n_o, 1'b0);
        chk("R2 aux rail does not reset", sys_rst_o, 1'b0);
        @(negedge clk); rail2_ok_i = 1'b1; rail3_ok_i = 1'b0; #1;
        chk("R7 rail3 fail follows", rail3_fail_n_o, 1'b0);
        chk("R7 rail2 recovers", rail2_fail_n_o, 1'b1);
        @(negedge clk); rail3_ok_i = 1'b1;
        cyc_n(2);
        chk("R10 rail bits sticky", fault_reg_o, 8'h98);

        // R10: watchdog pulse, and a source beats a same-cycle write
        wr_fr(8'hFF);
        @(negedge clk); wdog_exp_i = 1'b1;
        @(negedge clk); wdog_exp_i = 1'b0; #1;
        chk("R10 watchdog bit4 cleared", fault_reg_o, 8'hE8);
        @(negedge clk); wdog_exp_i = 1'b1; fr_we_i = 1'b1; fr_wdata_i = 8'hFF;
        @(negedge clk); wdog_exp_i = 1'b0; fr_we_i = 1'b0; #1;
        chk("R10 source wins over write", fault_reg_o, 8'hE8);
        wr_fr(8'h07);
        chk("R9 low bits forced zero", fault_reg_o, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule